// File: doc/BRIEF.md
# Serial Memory Command Front-End with Pause

This block is the slave side of a mode-0 serial peripheral interface for a small serial memory. It samples the serial clock, active-low select, data in, active-low pause and active-low write-guard pins with its own system clock. It collects the first byte of each selected frame as a command, MSB first, and then carries out that command. Status reads shift the status byte out on the data-out pin. Status writes shift one byte in and commit it when select is released. Memory array commands only produce a one-cycle strobe that carries their address, because the array data path lives elsewhere.

The status byte holds three things. Bit 7 is the guard-enable flag. Bit 1 is the write-enable latch. Bit 0 is a busy flag, which a parameterised internal write-cycle timer drives. A host can pause a frame mid-way with the pause pin, and framing resumes where it stopped. An unknown command silences the block until the next select falling edge. Status writes can be refused through a combination of the guard pin and the guard-enable flag.

Top module: `sfe_spi_front`

## Requirements
- R1: After reset the data-out enable is low, the array strobe is low, and a status read returns 0x00.
- R2: Data is taken from the data-in pin on rising serial clock edges and placed on the data-out pin after falling edges, MSB first in both directions. While the serial clock stays high, the data-out value does not change.
- R3: Command 0x06 sets the write-enable latch (status bit 1) and command 0x04 clears it. Command 0x05 returns the status byte {guard-enable, 5'b0, write-enable latch, busy} and repeats it for as long as clocking continues.
- R4: Command 0x01 followed by one data byte commits that byte's bit 7 into the guard-enable flag (status bit 7) at the select rising edge, clears the write-enable latch, and starts the busy period.
- R5: A status write with the write-enable latch clear has no effect.
- R6: While the guard-enable flag is 1 and the guard pin is low, a status write is refused and the latch stays set. While the flag is 0, the guard pin level has no effect.
- R7: If the guard pin goes low at any time during a selected status-write frame while the guard-enable flag is 1, the write is cancelled, even if the pin is high again when select rises.
- R8: A status write frame that carries more than one data byte does not commit.
- R9: Any command byte other than 0x06, 0x04, 0x05, 0x01, 0x03 and 0x02 keeps data-out disabled and produces no strobe until the next select falling edge. The frame after that works normally.
- R10: While select is high, data-in is ignored and data-out is disabled.
- R11: Pause starts when the pause pin is low while the serial clock is low, and ends when the pin is high while the clock is low. During a pause, clock edges are ignored, data-out is disabled, and the bit and byte positions are kept.
- R12: Commands 0x03 (read) and 0x02 (write) take two address bytes, MSB first. After the second byte, a single-cycle strobe appears with the 16-bit address and a write flag (1 for 0x02).
- R13: The busy flag (status bit 0) stays high for BUSY_CYC system clocks after a commit, then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| wp_n | input | 1 | Active-low status write guard |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for so (low means high impedance) |
| arr_strobe | output | 1 | One-cycle pulse for a decoded array command |
| arr_write | output | 1 | Array command is a write (valid with strobe) |
| arr_addr | output | ADDR_W | Array address collected from the frame |

## Verification
Most internal faults here show up at the ports within one frame. A wrong bit count or a lost shift makes the next status read come back rotated or shifted. A pause that does not freeze the counters corrupts the bytes that follow it. A lockout that does not hold lets data-out turn on inside the bad frame. Faults in the guard logic, the latch and the busy timer do not show at once. They appear as a wrong status byte on the next read, and the busy timer only shows when that read comes before or after BUSY_CYC clocks. So each status write is followed at once by a read, and again after the timer has expired.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [7:0] CMD_WEN_SET = 8'h06;
  localparam logic [7:0] CMD_WEN_CLR = 8'h04;
  localparam logic [7:0] CMD_STAT_RD = 8'h05;
  localparam logic [7:0] CMD_STAT_WR = 8'h01;
  localparam logic [7:0] CMD_ARR_RD  = 8'h03;
  localparam logic [7:0] CMD_ARR_WR  = 8'h02;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_STAT_OUT, PH_STAT_IN, PH_DRAIN, PH_LOCK
  } sfe_phase_e;
endpackage

// File: rtl/sfe_sampler.sv
module sfe_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic clk_rise,
  output logic clk_fall,
  output logic sel_fall,
  output logic sel_rise,
  output logic sel,
  output logic din,
  output logic guard,
  output logic held
);
  logic sck_q, sck_p, sel_q, sel_p, din_q, pause_q, guard_q, held_q;
  logic held_d;

  always_comb begin
    held_d = held_q;
    if (!sel_q)      held_d = 1'b0;
    else if (!sck_q) held_d = pause_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      sck_p   <= 1'b0;
      sel_q   <= 1'b0;
      sel_p   <= 1'b0;
      din_q   <= 1'b0;
      pause_q <= 1'b0;
      guard_q <= 1'b1;
      held_q  <= 1'b0;
    end else begin
      sck_q   <= sck;
      sck_p   <= sck_q;
      sel_q   <= ~cs_n;
      sel_p   <= sel_q;
      din_q   <= si;
      pause_q <= ~hold_n;
      guard_q <= wp_n;
      held_q  <= held_d;
    end
  end

  assign clk_rise = sck_q & ~sck_p;
  assign clk_fall = ~sck_q & sck_p;
  assign sel_fall = sel_q & ~sel_p;
  assign sel_rise = ~sel_q & sel_p;
  assign sel      = sel_q;
  assign din      = din_q;
  assign guard    = guard_q;
  assign held     = held_q;
endmodule

// File: rtl/sfe_ctrl.sv
module sfe_ctrl
  import sfe_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BUSY_CYC = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_rise,
  input  logic              clk_fall,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              sel,
  input  logic              din,
  input  logic              guard,
  input  logic              held,
  output logic              so,
  output logic              so_oe,
  output logic              arr_strobe,
  output logic              arr_write,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              locked
);
  localparam int ABYTES = ADDR_W / 8;
  localparam int CW     = (ABYTES > 1) ? $clog2(ABYTES) : 1;
  localparam int BW     = $clog2(BUSY_CYC + 1);

  sfe_phase_e        ph_q, ph_d;
  logic [2:0]        bit_q, bit_d, obit_q, obit_d;
  logic [6:0]        sh_q, sh_d;
  logic [CW-1:0]     acnt_q, acnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              isw_q, isw_d, stb_q, stb_d, so_q, so_d, oe_q, oe_d;
  logic [1:0]        wcnt_q, wcnt_d;
  logic              wbit_q, wbit_d, glow_q, glow_d;
  logic              wel_q, wel_d, gen_q, gen_d;
  logic [BW-1:0]     busy_q, busy_d;
  logic              act_rise, act_fall, byte_done, commit;
  logic [7:0]        rx_byte, status;

  assign act_rise  = clk_rise & sel & ~held;
  assign act_fall  = clk_fall & sel & ~held;
  assign byte_done = act_rise & (bit_q == 3'd7);
  assign rx_byte   = {sh_q, din};
  assign status    = {gen_q, 5'b00000, wel_q, (busy_q != '0)};
  assign commit    = sel_rise & (ph_q == PH_STAT_IN) & (wcnt_q == 2'd1) & wel_q
                   & ~(gen_q & (glow_q | ~guard));

  always_comb begin
    ph_d   = ph_q;   bit_d  = bit_q;  obit_d = obit_q; sh_d   = sh_q;
    acnt_d = acnt_q; addr_d = addr_q; isw_d  = isw_q;  stb_d  = 1'b0;
    so_d   = so_q;   wcnt_d = wcnt_q; wbit_d = wbit_q; glow_d = glow_q;
    wel_d  = wel_q;  gen_d  = gen_q;  busy_d = busy_q;
    if (sel_fall) begin
      ph_d   = PH_CMD;
      bit_d  = 3'd0;
      obit_d = 3'd0;
      wcnt_d = 2'd0;
      acnt_d = '0;
      glow_d = ~guard;
    end else begin
      if (sel && !guard) glow_d = 1'b1;
      if (act_rise && ph_q != PH_IDLE && ph_q != PH_LOCK) begin
        sh_d  = rx_byte[6:0];
        bit_d = bit_q + 3'd1;
      end
      if (byte_done) begin
        unique case (ph_q)
          PH_CMD: begin
            ph_d = PH_DRAIN;
            case (rx_byte)
              CMD_WEN_SET: wel_d = 1'b1;
              CMD_WEN_CLR: wel_d = 1'b0;
              CMD_STAT_RD: begin ph_d = PH_STAT_OUT; obit_d = 3'd0; end
              CMD_STAT_WR: ph_d = PH_STAT_IN;
              CMD_ARR_RD, CMD_ARR_WR: begin
                ph_d   = PH_ADDR;
                isw_d  = (rx_byte == CMD_ARR_WR);
                acnt_d = '0;
              end
              default: ph_d = PH_LOCK;
            endcase
          end
          PH_ADDR: begin
            addr_d = ADDR_W'({addr_q, rx_byte});
            if (acnt_q == CW'(ABYTES - 1)) begin
              stb_d = 1'b1;
              ph_d  = PH_DRAIN;
            end else begin
              acnt_d = acnt_q + 1'b1;
            end
          end
          PH_STAT_IN: begin
            if (wcnt_q == 2'd0) begin
              wbit_d = rx_byte[7];
              wcnt_d = 2'd1;
            end else begin
              wcnt_d = 2'd2;
            end
          end
          default: ;
        endcase
      end
      if (act_fall && ph_q == PH_STAT_OUT) begin
        so_d   = status[~obit_q];
        obit_d = obit_q + 3'd1;
      end
      if (sel_rise) ph_d = PH_IDLE;
    end
    if (commit) begin
      gen_d  = wbit_q;
      wel_d  = 1'b0;
      busy_d = BW'(BUSY_CYC);
    end else if (busy_q != '0) begin
      busy_d = busy_q - 1'b1;
    end
    oe_d = sel & ~held & (ph_q == PH_STAT_OUT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE; bit_q  <= '0;   obit_q <= '0;   sh_q   <= '0;
      acnt_q <= '0;      addr_q <= '0;   isw_q  <= 1'b0; stb_q  <= 1'b0;
      so_q   <= 1'b0;    oe_q   <= 1'b0; wcnt_q <= '0;   wbit_q <= 1'b0;
      glow_q <= 1'b0;    wel_q  <= 1'b0; gen_q  <= 1'b0; busy_q <= '0;
    end else begin
      ph_q   <= ph_d;    bit_q  <= bit_d;  obit_q <= obit_d; sh_q   <= sh_d;
      acnt_q <= acnt_d;  addr_q <= addr_d; isw_q  <= isw_d;  stb_q  <= stb_d;
      so_q   <= so_d;    oe_q   <= oe_d;   wcnt_q <= wcnt_d; wbit_q <= wbit_d;
      glow_q <= glow_d;  wel_q  <= wel_d;  gen_q  <= gen_d;  busy_q <= busy_d;
    end
  end

  assign so         = so_q;
  assign so_oe      = oe_q;
  assign arr_strobe = stb_q;
  assign arr_write  = isw_q;
  assign arr_addr   = addr_q;
  assign locked     = (ph_q == PH_LOCK);
endmodule

// File: rtl/sfe_spi_front.sv
module sfe_spi_front #(
  parameter int ADDR_W   = 16,
  parameter int BUSY_CYC = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hold_n,
  input  logic              wp_n,
  output logic              so,
  output logic              so_oe,
  output logic              arr_strobe,
  output logic              arr_write,
  output logic [ADDR_W-1:0] arr_addr
);
  logic rst_m, rst_s;
  logic clk_rise, clk_fall, sel_fall, sel_rise, sel, din, guard, held, locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  sfe_sampler u_smp (
    .clk(clk), .rst_n(rst_s), .sck(sck), .cs_n(cs_n), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .clk_rise(clk_rise), .clk_fall(clk_fall),
    .sel_fall(sel_fall), .sel_rise(sel_rise), .sel(sel), .din(din),
    .guard(guard), .held(held)
  );

  sfe_ctrl #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_s), .clk_rise(clk_rise), .clk_fall(clk_fall),
    .sel_fall(sel_fall), .sel_rise(sel_rise), .sel(sel), .din(din),
    .guard(guard), .held(held), .so(so), .so_oe(so_oe),
    .arr_strobe(arr_strobe), .arr_write(arr_write), .arr_addr(arr_addr),
    .locked(locked)
  );
endmodule

// File: rtl/sfe_spi_front_chk.sv
module sfe_spi_front_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cs_n,
  input logic so,
  input logic so_oe,
  input logic arr_strobe,
  input logic held,
  input logic locked
);
  AST_SO_HOLDS_WHILE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && sck && $past(sck) && $past(sck, 2)) |-> $stable(so)); // R2
  AST_LOCK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!so_oe && !arr_strobe)); // R9
  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_oe); // R10
  AST_PAUSE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> !so_oe); // R11
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_strobe |=> !arr_strobe); // R12
endmodule

bind sfe_spi_front sfe_spi_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .so(so), .so_oe(so_oe),
  .arr_strobe(arr_strobe), .held(held), .locked(locked)
);

// File: tb/test_sfe_spi_front.sv
module test_sfe_spi_front;
  localparam int HP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe, arr_strobe, arr_write;
  logic [15:0] arr_addr;

  int errs = 0, checks = 0, oe_viol = 0;
  bit watch_off = 1'b0;

  typedef struct {
    bit          is_strobe;
    logic [15:0] val;
    bit          wr;
    string       tag;
  } exp_t;
  exp_t expq[$];
  exp_t mon_e;

  sfe_spi_front i_sfe_spi_front (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .so(so), .so_oe(so_oe), .arr_strobe(arr_strobe),
    .arr_write(arr_write), .arr_addr(arr_addr)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (watch_off && so_oe !== 1'b0) oe_viol++;
    if (arr_strobe === 1'b1) begin
      if (expq.size() == 0 || !expq[0].is_strobe) begin
        checks++; errs++;
        $display("FAIL R12 unexpected strobe actual=%h expected=none", arr_addr);
      end else begin
        mon_e = expq.pop_front();
        check(mon_e.tag, arr_addr, mon_e.val);
        check(mon_e.tag, {15'd0, arr_write}, {15'd0, mon_e.wr});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pause();
    logic keep;
    keep = si;
    hold_n = 1'b0;
    wait_clk(3);
    watch_off = 1'b1;
    for (int k = 0; k < 3; k++) begin
      si = ~si; sck = 1'b1; wait_clk(2);
      sck = 1'b0; wait_clk(3);
    end
    si = keep;
    hold_n = 1'b1;
    watch_off = 1'b0;
    wait_clk(HP);
  endtask

  task automatic xfer(input logic [7:0] tx, input int hold_at, output logic [7:0] rx);
    for (int i = 0; i < 8; i++) begin
      si = tx[7-i];
      wait_clk(HP);
      rx[7-i] = so;
      if (i == hold_at) pause();
      sck = 1'b1;
      wait_clk(HP);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0; wait_clk(HP);
  endtask

  task automatic desel();
    wait_clk(HP); cs_n = 1'b1; wait_clk(2*HP);
  endtask

  task automatic cmd1(input logic [7:0] op, input int hold_at);
    logic [7:0] d;
    sel(); xfer(op, hold_at, d); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h01, 8, d); xfer(v, 8, d); desel();
  endtask

  task automatic rdsr(input logic [7:0] exp, input string tag, input int hold_at);
    logic [7:0] d, rx;
    exp_t e;
    e.is_strobe = 1'b0; e.val = {8'd0, exp}; e.wr = 1'b0; e.tag = tag;
    expq.push_back(e);
    sel(); xfer(8'h05, 8, d); xfer(8'h00, hold_at, rx); desel();
    e = expq.pop_front();
    check(e.tag, {8'd0, rx}, e.val);
  endtask

  task automatic arr_cmd(input logic [7:0] op, input logic [15:0] a, input string tag);
    logic [7:0] d;
    exp_t e;
    e.is_strobe = 1'b1; e.val = a; e.wr = (op == 8'h02); e.tag = tag;
    expq.push_back(e);
    sel(); xfer(op, 8, d); xfer(a[15:8], 8, d); xfer(a[7:0], 8, d);
    xfer(8'h55, 8, d); desel();
  endtask

  initial begin
    logic [7:0] d;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check("R1 so_oe after reset", {15'd0, so_oe}, 16'd0);
    check("R1 strobe after reset", {15'd0, arr_strobe}, 16'd0);
    rdsr(8'h00, "R1 status after reset", 8);

    cmd1(8'h06, 8);
    rdsr(8'h02, "R3 R2 latch set, MSB-first read", 8);
    cmd1(8'h04, 8);
    rdsr(8'h00, "R3 latch cleared", 8);

    wrsr(8'h80);
    rdsr(8'h00, "R5 write without latch ignored", 8);

    watch_off = 1'b1;
    xfer(8'h06, 8, d);
    watch_off = 1'b0;
    check("R10 data-out off while deselected", oe_viol[15:0], 16'd0);
    rdsr(8'h00, "R10 clocking while deselected ignored", 8);

    wp_n = 1'b0;
    cmd1(8'h06, 8);
    wrsr(8'h80);
    rdsr(8'h81, "R4 R6 commit with guard-enable 0 and pin low", 8);
    wait_clk(500);
    rdsr(8'h80, "R13 busy cleared after timer", 8);
    wp_n = 1'b1;

    cmd1(8'h06, 8);
    wp_n = 1'b0;
    wrsr(8'h00);
    rdsr(8'h82, "R6 refused with guard-enable 1 and pin low", 8);
    wp_n = 1'b1;

    sel(); xfer(8'h01, 8, d);
    wp_n = 1'b0; wait_clk(4); wp_n = 1'b1;
    xfer(8'h00, 8, d); desel();
    rdsr(8'h82, "R7 guard pulse mid-frame cancels", 8);

    sel(); xfer(8'h01, 8, d); xfer(8'h00, 8, d); xfer(8'h00, 8, d); desel();
    rdsr(8'h82, "R8 two data bytes do not commit", 8);

    wrsr(8'h00);
    rdsr(8'h01, "R4 commit clears flag and latch, busy set", 8);
    wait_clk(500);
    rdsr(8'h00, "R13 busy cleared", 8);

    oe_viol = 0;
    sel();
    watch_off = 1'b1;
    xfer(8'hAB, 8, d); xfer(8'h05, 8, d); xfer(8'h00, 8, d);
    watch_off = 1'b0;
    desel();
    check("R9 no output after bad command", oe_viol[15:0], 16'd0);
    rdsr(8'h00, "R9 next frame works", 8);

    arr_cmd(8'h03, 16'h1234, "R12 array read strobe");
    arr_cmd(8'h02, 16'hBEEF, "R12 array write strobe");

    oe_viol = 0;
    cmd1(8'h06, 3);
    rdsr(8'h02, "R11 pause in command and in data", 4);
    check("R11 data-out off during pause", oe_viol[15:0], 16'd0);
    cmd1(8'h04, 8);

    wait_clk(10);
    check("R12 all expected strobes seen", expq.size(), 16'd0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    wait_clk(150000);
    checks++; errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule